// File: doc/BRIEF.md
# Byte String Loader with Stop Byte

This block copies a run of bytes from a byte-wide memory into a bank of 32 registers of 32 bits each. Each byte goes into one byte lane of the current register, from the top lane (bits 31:24) down to the bottom lane (bits 7:0). After the bottom lane the block moves to the next register index, and index 31 wraps to 0. The block does not hold the register file. It drives a byte-lane write port, and the lanes it does not touch keep their old contents.

A load is started with a start address, a byte count of up to 127, a stop byte, a first destination register and two guarded register indices. It ends after the counted number of bytes, or right after the first byte that equals the stop byte, whichever comes first. A byte aimed at a guarded register is read but not written.

When the load ends, the block raises a one-cycle done strobe together with the number of bytes processed. This is the byte count if no stop byte was seen, or the zero-based position of the stop byte if one was seen.

Top module: `bytestr_term_load`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req` and `wr_en` are all low.
- R2: Bytes are read one per accepted read, where an accepted read is a cycle with both `rd_req` and `rd_ack` high. The k-th accepted read of a load uses address `start_addr + k`, modulo 2^AW.
- R3: Each byte written drives exactly one bit of `wr_be`. The lanes are used in the order bit 3 (data bits 31:24), then bit 2, bit 1 and bit 0. The byte appears on `wr_data` in the enabled lane, and every other lane of the register is left unchanged.
- R4: After the lane 0 byte, the next byte goes to lane 3 of register index + 1, with 31 wrapping to 0. The first byte of a load goes to lane 3 of `dest_reg`.
- R5: A byte is not written when the current register equals `guard_b`. It is also not written when `guard_a` is nonzero and equals the current register. When `guard_a` is 0 it guards nothing.
- R6: A byte equal to `stop_byte` is still written, unless guarded, and then the load ends. `result` is the zero-based position of that byte, and no further read is made.
- R7: If no byte matches, exactly `byte_cnt` bytes are read and `result` equals `byte_cnt`.
- R8: A `byte_cnt` of 0 raises `done` in the cycle after `start` with `result` = 0, and makes no read and no write.
- R9: `done` lasts one cycle, is never high while `busy` is high, and carries `result` in that cycle.
- R10: A `start` given while `busy` is high is ignored. The running load finishes with its own parameters.
- R11: While `rd_req` is high and `rd_ack` is low, `rd_addr` holds and no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (sampled when idle) |
| start_addr | input | AW | First byte address |
| byte_cnt | input | CW | Number of bytes to load |
| stop_byte | input | 8 | Compare value that ends the load |
| dest_reg | input | 5 | First destination register |
| guard_a | input | 5 | Guarded register, active only when nonzero |
| guard_b | input | 5 | Guarded register, always active |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read address |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Read byte |
| wr_en | output | 1 | Register lane write strobe |
| wr_idx | output | 5 | Register index written |
| wr_be | output | 4 | One-hot lane enable, bit 3 = bits 31:24 |
| wr_data | output | 32 | Byte placed in its lane |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | CW | Bytes processed, or position of the stop byte |

## Verification
Two endings can fall on the same byte. A stop-byte match can land on the final counted byte, where the count limit and the match end the load in the same cycle; the result must then be count - 1, not the count. A stop-byte match can also land on a guarded register, where the match must still end the load although nothing is written. Vectors are placed so that the stop byte sits at the last counted position, and on a lane of a register guarded by `guard_a`. They are judged by comparing the final register image, the read count and `result` against a bench model. A stalling acknowledge pattern is run alongside, so that endings also occur on cycles that follow waits.

// File: rtl/bstl_pkg.sv
package bstl_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int RIDX_W = 5;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [RIDX_W-1:0] ridx_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam lane_t LANE_TOP = lane_t'(LANES - 1);

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_FETCH = 1'b1} st_e;

  typedef struct packed {
    ridx_t ridx;
    lane_t lane;
  } slot_t;

  // One-hot lane enable for a given lane number.
  function automatic logic [LANES-1:0] lane_strobe(lane_t l);
    logic [LANES-1:0] one;
    one = {{(LANES-1){1'b0}}, 1'b1};
    return one << l;
  endfunction

  // Byte shifted into its lane position of a word.
  function automatic logic [WORD_W-1:0] lane_place(byte_t b, lane_t l);
    logic [WORD_W-1:0] w;
    w = {{(WORD_W-BYTE_W){1'b0}}, b};
    return w << (int'(l) * BYTE_W);
  endfunction

  // Next write slot: walk lanes downward, then move to the next register.
  function automatic slot_t slot_next(slot_t s);
    slot_t n;
    if (s.lane == '0) begin
      n.ridx = s.ridx + ridx_t'(1);
      n.lane = LANE_TOP;
    end else begin
      n.ridx = s.ridx;
      n.lane = s.lane - lane_t'(1);
    end
    return n;
  endfunction

  // Guard test: b always applies, a only when nonzero.
  function automatic logic slot_guarded(ridx_t cur, ridx_t ga, ridx_t gb);
    return (cur == gb) || ((ga != '0) && (cur == ga));
  endfunction
endpackage

// File: rtl/bstl_cursor.sv
module bstl_cursor
  import bstl_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base_addr,
  input  ridx_t         first_reg,
  output logic [AW-1:0] addr,
  output slot_t         slot,
  output logic [CW-1:0] idx
);
  logic [AW-1:0] addr_q;
  slot_t         slot_q;
  logic [CW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      slot_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      addr_q      <= base_addr;
      slot_q.ridx <= first_reg;
      slot_q.lane <= LANE_TOP;
      idx_q       <= '0;
    end else if (step) begin
      addr_q <= addr_q + AW'(1);
      slot_q <= slot_next(slot_q);
      idx_q  <= idx_q + CW'(1);
    end
  end

  assign addr = addr_q;
  assign slot = slot_q;
  assign idx  = idx_q;

  // R2: each accepted byte moves the address on by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr_q == $past(addr_q) + AW'(1)));

  // R3: lanes are walked downward inside one register
  a_r3_lane_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && slot_q.lane != '0) |=>
      (slot_q.lane == $past(slot_q.lane) - lane_t'(1)) && $stable(slot_q.ridx));

  // R4: after the bottom lane, the top lane of the next register
  a_r4_reg_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && slot_q.lane == '0) |=>
      (slot_q.lane == LANE_TOP) && (slot_q.ridx == ridx_t'($past(slot_q.ridx) + ridx_t'(1))));

  // R4: a load begins at the top lane of the destination
  a_r4_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (slot_q.lane == LANE_TOP) && (slot_q.ridx == $past(first_reg)) && (idx_q == '0));
endmodule

// File: rtl/bstl_guard.sv
module bstl_guard
  import bstl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  ridx_t              guard_a_in,
  input  ridx_t              guard_b_in,
  input  logic               accept,
  input  byte_t              rd_byte,
  input  slot_t              slot,
  output logic               wr_en,
  output ridx_t              wr_idx,
  output logic [LANES-1:0]   wr_be,
  output logic [WORD_W-1:0]  wr_data
);
  ridx_t ga_q, gb_q;
  logic  blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ga_q <= '0;
      gb_q <= '0;
    end else if (load) begin
      ga_q <= guard_a_in;
      gb_q <= guard_b_in;
    end
  end

  always_comb begin
    blocked = slot_guarded(slot.ridx, ga_q, gb_q);
    wr_en   = accept && !blocked;
    wr_idx  = slot.ridx;
    wr_be   = lane_strobe(slot.lane);
    wr_data = lane_place(rd_byte, slot.lane);
  end

  // R5: the always-active guard is never written
  a_r5_guard_b: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != gb_q));

  // R5: the conditional guard is never written when nonzero
  a_r5_guard_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ga_q != '0) |-> (wr_idx != ga_q));

  // R3: exactly one lane per write
  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_be) == 1));

  // R11: writes only happen on an accepted read
  a_r11_write_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> accept);
endmodule

// File: rtl/bstl_ctrl.sv
module bstl_ctrl
  import bstl_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt_in,
  input  byte_t         key_in,
  input  logic [CW-1:0] idx,
  input  logic          rd_ack,
  input  byte_t         rd_byte,
  output logic          busy,
  output logic          load,
  output logic          accept,
  output logic          done,
  output logic [CW-1:0] result
);
  st_e           st;
  logic [CW-1:0] cnt_q;
  byte_t         key_q;
  logic          done_q;
  logic [CW-1:0] result_q;
  logic          hit, last, finish, zero_go;

  always_comb begin
    busy    = (st == ST_FETCH);
    load    = (st == ST_IDLE) && start;
    accept  = busy && rd_ack;
    hit     = (rd_byte == key_q);
    last    = (idx == cnt_q - CW'(1));
    finish  = accept && (hit || last);
    zero_go = load && (cnt_in == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt_q    <= '0;
      key_q    <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= zero_go || finish;
      if (load) begin
        cnt_q <= cnt_in;
        key_q <= key_in;
        if (zero_go) result_q <= '0;
        else         st       <= ST_FETCH;
      end
      if (finish) begin
        st       <= ST_IDLE;
        result_q <= hit ? idx : cnt_q;
      end
    end
  end

  assign done   = done_q;
  assign result = result_q;

  // R9: completion is never reported during a load
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: the count reported never exceeds the requested count
  a_r7_result_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result <= cnt_q));

  // R8: zero count finishes at once with a zero result
  a_r8_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cnt_in == '0) |=> (done && !busy && result == '0));

  // R6: a matching byte ends the load with its position
  a_r6_hit_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (done && !busy && result == $past(idx)));

  // R10: a start during a load does not disturb its parameters
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(cnt_q) && $stable(key_q)));

  // R11: a wait holds the position
  a_r11_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_ack) |=> (busy && $stable(idx)));
endmodule

// File: rtl/bytestr_term_load.sv
module bytestr_term_load
  import bstl_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] byte_cnt,
  input  logic [7:0]    stop_byte,
  input  logic [4:0]    dest_reg,
  input  logic [4:0]    guard_a,
  input  logic [4:0]    guard_b,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [4:0]    wr_idx,
  output logic [3:0]    wr_be,
  output logic [31:0]   wr_data,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] result
);
  logic          load_w, accept_w, busy_w;
  logic [CW-1:0] idx_w;
  slot_t         slot_w;

  bstl_ctrl #(.CW(CW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(byte_cnt),
    .key_in(stop_byte), .idx(idx_w), .rd_ack(rd_ack), .rd_byte(rd_data),
    .busy(busy_w), .load(load_w), .accept(accept_w), .done(done), .result(result)
  );

  bstl_cursor #(.AW(AW), .CW(CW)) cursor_i (
    .clk(clk), .rst_n(rst_n), .load(load_w), .step(accept_w),
    .base_addr(start_addr), .first_reg(dest_reg),
    .addr(rd_addr), .slot(slot_w), .idx(idx_w)
  );

  bstl_guard guard_i (
    .clk(clk), .rst_n(rst_n), .load(load_w),
    .guard_a_in(guard_a), .guard_b_in(guard_b),
    .accept(accept_w), .rd_byte(rd_data), .slot(slot_w),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be), .wr_data(wr_data)
  );

  assign rd_req = busy_w;
  assign busy   = busy_w;

  // R11: a pending read keeps its address
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> $stable(rd_addr));

  // R9: no read is requested in the completion cycle
  a_r9_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);
endmodule

// File: tb/bytestr_term_load_tb_top.sv
module bytestr_term_load_tb_top;
  localparam int AW = 16;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic [7:0]    stop_byte = '0;
  logic [4:0]    dest_reg = '0, guard_a = '0, guard_b = '0;
  logic          rd_req, rd_ack, wr_en, busy, done;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic [4:0]    wr_idx;
  logic [3:0]    wr_be;
  logic [31:0]   wr_data;
  logic [CW-1:0] result;

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int reads = 0, addr_err = 0, wr_err = 0;
  logic [AW-1:0] exp_addr = '0;
  logic stall_mode = 1'b0, stall_ph = 1'b0, ack_block = 1'b0;
  logic [31:0] tb_rf [32];
  logic [31:0] ex_rf [32];

  function automatic logic [7:0] memf(logic [15:0] a);
    return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ 8'h5A;
  endfunction

  assign rd_data = memf(rd_addr);
  assign rd_ack  = rd_req && !ack_block && (!stall_mode || stall_ph);

  bytestr_term_load #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_cnt(byte_cnt), .stop_byte(stop_byte), .dest_reg(dest_reg),
    .guard_a(guard_a), .guard_b(guard_b), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_be(wr_be), .wr_data(wr_data), .busy(busy), .done(done), .result(result)
  );

  // Bench-side register file and read monitor
  always @(posedge clk) begin
    stall_ph <= ~stall_ph;
    if (rst_n && rd_req && rd_ack) begin
      if (rd_addr != exp_addr) addr_err++;
      exp_addr = exp_addr + 16'd1;
      reads++;
    end
    if (rst_n && wr_en) begin
      if (!(rd_req && rd_ack)) wr_err++;
      for (int k = 0; k < 4; k++)
        if (wr_be[k]) tb_rf[wr_idx][k*8 +: 8] = wr_data[k*8 +: 8];
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic preload();
    for (int i = 0; i < 32; i++) begin
      tb_rf[i] = {8'(i), 8'hC3, 8'(i * 5), 8'h3C};
      ex_rf[i] = tb_rf[i];
    end
  endtask

  // Model: byte offsets 24,16,8,0 per register, guards, stop byte
  task automatic model(input logic [15:0] a, input int n, input logic [7:0] key,
                       input int d, input int ga, input int gb,
                       output int res, output int nrd);
    int r, off;
    logic [7:0] b;
    r = d; off = 24; res = n; nrd = n;
    for (int i = 0; i < n; i++) begin
      b = memf(a + 16'(i));
      if (!(r == gb || (ga != 0 && r == ga))) ex_rf[r][off +: 8] = b;
      if (b == key) begin res = i; nrd = i + 1; break; end
      if (off == 0) begin off = 24; r = (r + 1) % 32; end
      else off -= 8;
    end
  endtask

  function automatic int rf_mismatch();
    int m = 0;
    for (int i = 0; i < 32; i++) if (tb_rf[i] !== ex_rf[i]) m++;
    return m;
  endfunction

  task automatic drive(input logic [15:0] a, input int n, input logic [7:0] key,
                       input int d, input int ga, input int gb);
    start_addr = a; byte_cnt = CW'(n); stop_byte = key;
    dest_reg = 5'(d); guard_a = 5'(ga); guard_b = 5'(gb);
  endtask

  // Waits for done; returns captured result, -1 on timeout
  task automatic wait_done(output int res);
    int cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    res = done ? int'(result) : -1;
  endtask

  // addr, cnt, stop offset, dest, guard_a, guard_b, stall
  localparam logic [63:0] VEC [8] = '{
    64'h0100_09_64_05_00_00_00,
    64'h0200_0C_06_1E_00_1F_01,
    64'h0300_14_64_1D_1E_00_00,
    64'h0400_08_07_02_00_03_01,
    64'h0500_0A_00_00_00_04_00,
    64'h0600_7F_7E_0A_0C_0B_01,
    64'h0700_05_02_07_07_00_00,
    64'hFFFE_06_32_0E_00_00_01
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int res, eres, enrd, r0;
    logic [15:0] a;
    logic [7:0] key;
    preload();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !rd_req && !wr_en, "R1", "idle after reset",
        int'({busy, done, rd_req, wr_en}), 0);

    // Vector table
    for (int v = 0; v < 8; v++) begin
      a = VEC[v][63:48];
      key = memf(a + 16'(VEC[v][39:32]));
      preload();
      model(a, int'(VEC[v][46:40]), key, int'(VEC[v][31:24]),
            int'(VEC[v][23:16]), int'(VEC[v][15:8]), eres, enrd);
      stall_mode = VEC[v][0];
      reads = 0; addr_err = 0; wr_err = 0; exp_addr = a;
      drive(a, int'(VEC[v][46:40]), key, int'(VEC[v][31:24]),
            int'(VEC[v][23:16]), int'(VEC[v][15:8]));
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(res);
      chk(res == eres, "R6/R7", $sformatf("vec %0d result", v), res, eres);
      chk(reads == enrd, "R7", $sformatf("vec %0d read count", v), reads, enrd);
      chk(addr_err == 0, "R2", $sformatf("vec %0d addresses", v), addr_err, 0);
      chk(rf_mismatch() == 0, "R3/R4/R5", $sformatf("vec %0d register image", v), rf_mismatch(), 0);
      chk(wr_err == 0, "R11", $sformatf("vec %0d write without ack", v), wr_err, 0);
      @(negedge clk);
      chk(!done, "R9", $sformatf("vec %0d done one cycle", v), int'(done), 0);
    end
    stall_mode = 1'b0;

    // R8: zero count
    preload(); reads = 0; wr_err = 0;
    drive(16'h0800, 0, 8'h00, 3, 0, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1, "R8", "done next cycle", int'(done), 1);
    chk(int'(result) == 0, "R8", "zero result", int'(result), 0);
    repeat (3) @(negedge clk);
    chk(reads == 0 && rf_mismatch() == 0, "R8", "no access", reads, 0);

    // R10: start while busy is ignored
    preload(); reads = 0; addr_err = 0; exp_addr = 16'h0900;
    stall_mode = 1'b1;
    key = memf(16'h0900 + 16'd200);
    model(16'h0900, 10, key, 12, 0, 0, eres, enrd);
    drive(16'h0900, 10, key, 12, 0, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    drive(16'h0A00, 3, 8'h00, 20, 0, 12);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(res);
    chk(res == eres, "R10", "first load result kept", res, eres);
    repeat (3) @(negedge clk);
    chk(!busy && reads == enrd, "R10", "no second load", reads, enrd);
    chk(rf_mismatch() == 0 && addr_err == 0, "R10", "register image", rf_mismatch(), 0);
    stall_mode = 1'b0;

    // R11: a held acknowledge freezes the address and suppresses writes
    preload(); reads = 0; exp_addr = 16'h0B00;
    ack_block = 1'b1;
    drive(16'h0B00, 4, memf(16'h0B00 + 16'd90), 1, 0, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r0 = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (rd_addr != 16'h0B00 || wr_en || !rd_req) r0++;
    end
    chk(r0 == 0, "R11", "hold while waiting", r0, 0);
    ack_block = 1'b0;
    wait_done(res);
    chk(res == 4 && reads == 4, "R11", "resume after wait", res, 4);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule